// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a host register port and a serial shift engine. It holds a transmit FIFO and a receive FIFO of the same depth. It reports how many entries each FIFO holds and gives a compact status word. It also raises latched error events, live threshold interrupts and per-direction DMA requests. The serial shifting and the bit clock are outside this block. The engine only sees a pop handshake on the transmit side and a push handshake on the receive side.

The host reads and writes word registers through a single-cycle strobe port. Read data is combinational from the address. A read strobe has a side effect only at the receive data address, where it pops one entry. Software enables the block through a control register. While the enable is low, both FIFOs are held flushed and no traffic is accepted. The threshold and DMA level registers keep only values below the FIFO depth, so software can find the depth by writing and reading back.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset both levels read 0, the status word (address 5) reads 0x0C, the thresholds read 0, the raw interrupt word (address 8) reads 0x11, and irq and both DMA requests are low.
- R2: The transmit level (address 3) counts host writes to the transmit data port (address 13) less engine pops. The receive level (address 4) counts engine pushes less host reads of the receive data port (address 14). Status bits: 1 = transmit full, 2 = transmit empty, 3 = receive empty, 4 = receive full.
- R3: A write to the transmit data port while that FIFO is full stores nothing and latches raw interrupt bit 1 (transmit overflow).
- R4: A host read of the receive data port while that FIFO is empty latches raw bit 2 (receive underflow). An engine push while the receive FIFO is full drops the word and latches raw bit 3 (receive overflow).
- R5: A write to the clear register (address 9) removes latched events. Bit 3 clears transmit overflow, bit 1 clears receive underflow, bit 2 clears receive overflow, and bit 0 clears all three.
- R6: A write to the transmit threshold (address 1), receive threshold (address 2) or either DMA level (addresses 11, 12) takes effect only when the value is below the FIFO depth. Otherwise the register keeps its previous value.
- R7: Raw bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is at or above the receive threshold.
- R8: The masked interrupt word (address 7) is the raw word ANDed with the mask register (address 6). The irq output is high when any masked bit is set.
- R9: With DMA control (address 10) bit 1 set and the block enabled, dma_tx_req is high while the transmit level is at or below the transmit DMA level (address 11). With bit 0 set, dma_rx_req is high while the receive level is above the receive DMA level (address 12).
- R10: Writing 0 to bit 0 of the control register (address 0) flushes both FIFOs to level 0. While disabled, transmit data writes and engine pushes are ignored.
- R11: Status bit 0 (busy) is high while the block is enabled and either the engine reports busy or the transmit FIFO holds data.
- R12: Both FIFOs deliver words in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at receive data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| eng_busy | input | 1 | Shift engine is mid-frame |
| eng_tx_valid | output | 1 | Transmit FIFO holds a word for the engine |
| eng_tx_data | output | 16 | Head of the transmit FIFO |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 16 | Received word |
| irq | output | 1 | OR of the masked interrupt bits |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that each strobe lasts one cycle per intended access and that the engine pops only while eng_tx_valid is high. They also assume that the reset lasts at least one clock edge. The bench drives every strobe for exactly one cycle from the falling edge. It pops the transmit FIFO only after seeing eng_tx_valid. It runs the overflow and underflow cases on purpose through the host and engine ports, so the checks observe the drop behaviour instead of the assertions breaking.

// File: rtl/spi_fifo_pkg.sv
// Shared register addresses and bit positions for the SPI FIFO status unit.
package spi_fifo_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL       = 4'd0,
        A_TX_THR     = 4'd1,
        A_RX_THR     = 4'd2,
        A_TX_LVL     = 4'd3,
        A_RX_LVL     = 4'd4,
        A_STATUS     = 4'd5,
        A_MASK       = 4'd6,
        A_IRQ_MASKED = 4'd7,
        A_IRQ_RAW    = 4'd8,
        A_CLEAR      = 4'd9,
        A_DMA_CTL    = 4'd10,
        A_DMA_TX_LVL = 4'd11,
        A_DMA_RX_LVL = 4'd12,
        A_TX_DATA    = 4'd13,
        A_RX_DATA    = 4'd14
    } reg_addr_e;

    // interrupt bit positions
    localparam int IRQ_TX_LOW  = 0;
    localparam int IRQ_TX_OVF  = 1;
    localparam int IRQ_RX_UDF  = 2;
    localparam int IRQ_RX_OVF  = 3;
    localparam int IRQ_RX_HIGH = 4;
    localparam int IRQ_W       = 5;

    // clear register bit positions
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UDF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;
    localparam int CLR_W      = 4;
endpackage

// File: rtl/spi_fifo_buf.sv
// Synchronous FIFO with level counter and synchronous flush.
// Assumes: push when full and pop when empty are dropped silently; flush wins over both.
module spi_fifo_buf #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);
    assert_flush_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/spi_irq_unit.sv
// Latches error events, combines them with live threshold flags, applies the mask.
// Assumes: a set event in the same cycle as its clear wins.
module spi_irq_unit
    import spi_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_tx_ovf,
    input  logic             set_rx_udf,
    input  logic             set_rx_ovf,
    input  logic             clr_we,
    input  logic [CLR_W-1:0] clr,
    input  logic             tx_low,
    input  logic             rx_high,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic ev_tx_ovf, ev_rx_udf, ev_rx_ovf;
    logic kill_tx_ovf, kill_rx_udf, kill_rx_ovf;

    assign kill_tx_ovf = clr_we && (clr[CLR_ALL] || clr[CLR_TX_OVF]);
    assign kill_rx_udf = clr_we && (clr[CLR_ALL] || clr[CLR_RX_UDF]);
    assign kill_rx_ovf = clr_we && (clr[CLR_ALL] || clr[CLR_RX_OVF]);

    // Sticky event flags, cleared per source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_tx_ovf <= 1'b0;
            ev_rx_udf <= 1'b0;
            ev_rx_ovf <= 1'b0;
        end else begin
            if (set_tx_ovf)       ev_tx_ovf <= 1'b1;
            else if (kill_tx_ovf) ev_tx_ovf <= 1'b0;
            if (set_rx_udf)       ev_rx_udf <= 1'b1;
            else if (kill_rx_udf) ev_rx_udf <= 1'b0;
            if (set_rx_ovf)       ev_rx_ovf <= 1'b1;
            else if (kill_rx_ovf) ev_rx_ovf <= 1'b0;
        end
    end

    // Assemble raw, masked and summary outputs.
    always_comb begin
        raw = '0;
        raw[IRQ_TX_LOW]  = tx_low;
        raw[IRQ_TX_OVF]  = ev_tx_ovf;
        raw[IRQ_RX_UDF]  = ev_rx_udf;
        raw[IRQ_RX_OVF]  = ev_rx_ovf;
        raw[IRQ_RX_HIGH] = rx_high;
        masked = raw & mask;
        irq    = |masked;
    end

    assert_event_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx_ovf |=> raw[IRQ_TX_OVF]);
    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr[CLR_ALL] && !set_tx_ovf && !set_rx_udf && !set_rx_ovf)
        |=> (raw[IRQ_RX_OVF:IRQ_TX_OVF] == '0));
    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/spi_fifo_status.sv
// Register front end for an SPI engine: two FIFOs, thresholds, status,
// interrupts and DMA requests. Assumes DATA_W <= REG_W and one-cycle strobes.
module spi_fifo_status
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_busy,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              en;
    logic [PTR_W-1:0]  tx_thr, rx_thr, dma_tx_lvl, dma_rx_lvl;
    logic [IRQ_W-1:0]  mask, raw, masked;
    logic [1:0]        dma_ctl;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              wr_tx, rd_rx, fits, busy;
    logic [4:0]        status;

    assign wr_tx = reg_wr && (reg_addr == A_TX_DATA) && en;
    assign rd_rx = reg_rd && (reg_addr == A_RX_DATA) && en;
    assign fits  = (reg_wdata < REG_W'(DEPTH));

    // Configuration registers; level-type registers hold only in-range values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            tx_thr     <= '0;
            rx_thr     <= '0;
            dma_tx_lvl <= '0;
            dma_rx_lvl <= '0;
            mask       <= '0;
            dma_ctl    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL:       en         <= reg_wdata[0];
                A_TX_THR:     if (fits) tx_thr     <= reg_wdata[PTR_W-1:0];
                A_RX_THR:     if (fits) rx_thr     <= reg_wdata[PTR_W-1:0];
                A_DMA_TX_LVL: if (fits) dma_tx_lvl <= reg_wdata[PTR_W-1:0];
                A_DMA_RX_LVL: if (fits) dma_rx_lvl <= reg_wdata[PTR_W-1:0];
                A_MASK:       mask       <= reg_wdata[IRQ_W-1:0];
                A_DMA_CTL:    dma_ctl    <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    spi_fifo_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .flush(!en),
        .push(wr_tx), .push_data(reg_wdata[DATA_W-1:0]),
        .pop(eng_tx_pop && en), .head(eng_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    spi_fifo_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .flush(!en),
        .push(eng_rx_push && en), .push_data(eng_rx_data),
        .pop(rd_rx), .head(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    spi_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_tx_ovf(wr_tx && tx_full),
        .set_rx_udf(rd_rx && rx_empty),
        .set_rx_ovf(eng_rx_push && en && rx_full),
        .clr_we(reg_wr && (reg_addr == A_CLEAR)),
        .clr(reg_wdata[CLR_W-1:0]),
        .tx_low(tx_cnt <= CNT_W'(tx_thr)),
        .rx_high(rx_cnt >= CNT_W'(rx_thr)),
        .mask(mask), .raw(raw), .masked(masked), .irq(irq));

    assign eng_tx_valid = !tx_empty;
    assign busy         = en && (eng_busy || !tx_empty);
    assign status       = {rx_full, rx_empty, tx_empty, tx_full, busy};
    assign dma_tx_req   = en && dma_ctl[1] && (tx_cnt <= CNT_W'(dma_tx_lvl));
    assign dma_rx_req   = en && dma_ctl[0] && (rx_cnt >  CNT_W'(dma_rx_lvl));

    // Read-data multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:       reg_rdata = REG_W'(en);
            A_TX_THR:     reg_rdata = REG_W'(tx_thr);
            A_RX_THR:     reg_rdata = REG_W'(rx_thr);
            A_TX_LVL:     reg_rdata = REG_W'(tx_cnt);
            A_RX_LVL:     reg_rdata = REG_W'(rx_cnt);
            A_STATUS:     reg_rdata = REG_W'(status);
            A_MASK:       reg_rdata = REG_W'(mask);
            A_IRQ_MASKED: reg_rdata = REG_W'(masked);
            A_IRQ_RAW:    reg_rdata = REG_W'(raw);
            A_DMA_CTL:    reg_rdata = REG_W'(dma_ctl);
            A_DMA_TX_LVL: reg_rdata = REG_W'(dma_tx_lvl);
            A_DMA_RX_LVL: reg_rdata = REG_W'(dma_rx_lvl);
            A_RX_DATA:    reg_rdata = rx_empty ? '0 : REG_W'(rx_head);
            default:      reg_rdata = '0;
        endcase
    end

    assert_thr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_TX_THR) && !fits) |=> $stable(tx_thr));
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!dma_tx_req && !dma_rx_req));
    assert_disable_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_cnt == '0 && rx_cnt == '0));
endmodule

// File: tb/spi_fifo_status_test.sv
module spi_fifo_status_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_busy = 1'b0;
    logic        eng_tx_valid;
    logic [15:0] eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [15:0] eng_rx_data = '0;
    logic        irq, dma_tx_req, dma_rx_req;

    int errors = 0;
    int checks = 0;

    spi_fifo_status #(.DEPTH(DEPTH), .DATA_W(16), .REG_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic restart();
        wr(4'd0, 16'd0); wr(4'd0, 16'd1); wr(4'd9, 16'h1);
        wr(4'd6, 16'd0); wr(4'd10, 16'd0);
        wr(4'd1, 16'd0); wr(4'd2, 16'd0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'd5, v); chk("R1 status", v, 16'h0C);
        rd(4'd3, v); chk("R1 tx level", v, 0);
        rd(4'd4, v); chk("R1 rx level", v, 0);
        rd(4'd8, v); chk("R1 raw", v, 16'h11);
        rd(4'd1, v); chk("R1 tx thr", v, 0);
        chk("R1 irq/dma", {13'd0, irq, dma_tx_req, dma_rx_req}, 0);
    endtask

    task automatic t_tx_fill();
        logic [15:0] v;
        restart();
        for (int i = 0; i < DEPTH; i++) wr(4'd13, 16'hA0 + 16'(i));
        rd(4'd3, v); chk("R2 tx level full", v, 8);
        rd(4'd5, v); chk("R2 R11 status tx full busy", v, 16'h0B);
        wr(4'd13, 16'hEE);
        rd(4'd3, v); chk("R3 level after overflow", v, 8);
        rd(4'd8, v); chk("R3 raw overflow", v & 16'h0E, 16'h02);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk("R12 tx order", eng_tx_data, 16'hA0 + 16'(i));
            eng_tx_pop = 1'b1;
            @(negedge clk);
            eng_tx_pop = 1'b0;
        end
        chk("R2 tx drained", {15'd0, eng_tx_valid}, 0);
    endtask

    task automatic t_rx();
        logic [15:0] v;
        restart();
        for (int i = 0; i < 3; i++) push(16'h51 + 16'(i));
        rd(4'd4, v); chk("R2 rx level", v, 3);
        for (int i = 0; i < 3; i++) begin
            rd(4'd14, v); chk("R12 rx order", v, 16'h51 + 16'(i));
        end
        rd(4'd8, v); chk("R4 no underflow yet", v & 16'h04, 0);
        rd(4'd14, v);
        rd(4'd8, v); chk("R4 underflow", v & 16'h04, 16'h04);
        for (int i = 0; i <= DEPTH; i++) push(16'h60 + 16'(i));
        rd(4'd4, v); chk("R4 rx level capped", v, 8);
        rd(4'd8, v); chk("R4 overflow", v & 16'h08, 16'h08);
        rd(4'd5, v); chk("R2 status rx full", v, 16'h14);
        for (int i = 0; i < DEPTH; i++) rd(4'd14, v);
        chk("R4 dropped word not stored", v, 16'h67);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(4'd9, 16'h4);
        rd(4'd8, v); chk("R5 clear rx overflow only", v & 16'h0E, 16'h04);
        wr(4'd9, 16'h1);
        rd(4'd8, v); chk("R5 clear all", v & 16'h0E, 0);
    endtask

    task automatic t_thr();
        logic [15:0] v;
        wr(4'd1, 16'd5);  rd(4'd1, v); chk("R6 in range held", v, 5);
        wr(4'd1, 16'd8);  rd(4'd1, v); chk("R6 depth rejected", v, 5);
        wr(4'd1, 16'd15); rd(4'd1, v); chk("R6 large rejected", v, 5);
        wr(4'd11, 16'd9); rd(4'd11, v); chk("R6 dma level rejected", v, 0);
        wr(4'd1, 16'd0);  rd(4'd1, v); chk("R6 zero held", v, 0);
    endtask

    task automatic t_live();
        logic [15:0] v;
        restart();
        wr(4'd1, 16'd1); wr(4'd2, 16'd2);
        rd(4'd8, v); chk("R7 tx low empty", v & 16'h11, 16'h01);
        wr(4'd13, 16'h1); wr(4'd13, 16'h2);
        rd(4'd8, v); chk("R7 tx above thr", v & 16'h01, 0);
        push(16'h3);
        rd(4'd8, v); chk("R7 rx below thr", v & 16'h10, 0);
        push(16'h4);
        rd(4'd8, v); chk("R7 rx at thr", v & 16'h10, 16'h10);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        restart();
        wr(4'd6, 16'h08);
        chk("R8 masked idle irq", {15'd0, irq}, 0);
        for (int i = 0; i <= DEPTH; i++) push(16'(i));
        chk("R8 irq on overflow", {15'd0, irq}, 1);
        rd(4'd7, v); chk("R8 masked word", v, 16'h08);
        wr(4'd6, 16'h10);
        rd(4'd7, v); chk("R8 masked rx high", v, 16'h10);
        wr(4'd6, 16'h00);
        chk("R8 irq off", {15'd0, irq}, 0);
    endtask

    task automatic t_dma();
        restart();
        wr(4'd11, 16'd2); wr(4'd12, 16'd1);
        chk("R9 disabled by control", {14'd0, dma_tx_req, dma_rx_req}, 0);
        wr(4'd10, 16'd3);
        chk("R9 tx req low level", {14'd0, dma_tx_req, dma_rx_req}, 2);
        for (int i = 0; i < 3; i++) wr(4'd13, 16'(i));
        chk("R9 tx req drops", {15'd0, dma_tx_req}, 0);
        push(16'h1);
        chk("R9 rx at level", {15'd0, dma_rx_req}, 0);
        push(16'h2);
        chk("R9 rx above level", {15'd0, dma_rx_req}, 1);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        wr(4'd0, 16'd0);
        rd(4'd3, v); chk("R10 tx flushed", v, 0);
        rd(4'd4, v); chk("R10 rx flushed", v, 0);
        wr(4'd13, 16'h77); push(16'h88);
        wr(4'd0, 16'd1);
        rd(4'd3, v); chk("R10 tx write ignored", v, 0);
        rd(4'd4, v); chk("R10 push ignored", v, 0);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        restart();
        rd(4'd5, v); chk("R11 idle", v & 16'h1, 0);
        eng_busy = 1'b1;
        rd(4'd5, v); chk("R11 engine busy", v & 16'h1, 1);
        eng_busy = 1'b0;
        rd(4'd5, v); chk("R11 idle again", v & 16'h1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_fill();
        t_rx();
        t_clear();
        t_thr();
        t_live();
        t_mask();
        t_dma();
        t_disable();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule